// File: doc/BRIEF.md
# Circular Return Address Stack

This block is the call stack of a small controller core. When the core calls a subroutine, takes a trap or enters an interrupt, it pulses a strobe. The block then saves a context word in one of twelve slots. The word holds the return program counter, the low four condition flags, the two register-bank selects and the global interrupt enable. On a return, the core pulses the pop strobe and the block hands back the saved program counter. In the same cycle it presents the condition register, the bank selects and the interrupt enable that the core should load.

Two fields of the return instruction decide what is restored. `ret_g_i` can leave the interrupt enable alone, reload it from the saved word, or force it to a given level. `ret_rf_i` chooses whether the saved flags and bank selects replace the live ones. For traps, the block also forms the vector address from an 8-bit base and a 6-bit vector number.

The stack pointer never reports overflow. It wraps modulo twelve, so the thirteenth push silently overwrites the oldest slot.

The pointer logic is a three-way operation selector with these states:
- `OP_IDLE`: the pointer holds.
- `OP_PUSH`: entered on `push_i` or `trap_i`. The slot at the pointer is written, then the pointer advances from 11 to 0.
- `OP_POP`: entered on `pop_i`. The pointer steps back from 0 to 11 and the slot it lands on is read.

Each cycle selects its state afresh from the strobes.

Top module: `ctx_return_stack`

## Requirements
- R1: Reset sets the pointer to slot 0. After reset, a single push followed by a pop returns the value just pushed. Slot contents are not cleared by reset.
- R2: Entries come back in last-in, first-out order. The pop outputs are valid combinationally in the cycle `pop_i` is high, and the pointer moves at that cycle's clock edge.
- R3: A push writes the slot at the pointer and then advances the pointer, wrapping from 11 to 0. The thirteenth push overwrites the first one.
- R4: A pop first steps the pointer back, wrapping from 0 to 11, and then reads that slot.
- R5: A saved word packs the following fields:
  - bits 15:0: program counter
  - bits 19:16: flags N, V, C, Z, taken from `ccr_i[3:0]`
  - bit 20: bank select B
  - bit 21: bank select A
  - bit 22: interrupt enable

  A pop always drives `ret_pc_o` from bits 15:0.
- R6: When no pop is in progress, or on a pop with `ret_rf_i` = 0, the outputs `ccr_o`, `bank_a_o` and `bank_b_o` equal their inputs.
- R7: On a pop with `ret_rf_i` = 1, `ccr_o` = {`ccr_i[7:4]`, saved flags}, and both bank outputs take their saved values.
- R8: On a pop with `ret_g_i[1]` = 1, `gie_o` equals `ret_g_i[0]`.
- R9: On a pop with `ret_g_i` = 2'b01, `gie_o` equals the saved interrupt enable.
- R10: With `ret_g_i` = 2'b00, or when no pop is in progress, `gie_o` equals `gie_i`.
- R11: `trap_i` pushes exactly like `push_i`. `vec_pc_o` = {`vec_base_i`, 2'b00, `vec_num_i`}.
- R12: A push (or trap) and a pop are never requested in the same cycle. Strobes in adjacent cycles must each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Call push strobe |
| trap_i | input | 1 | Trap or interrupt push strobe |
| pop_i | input | 1 | Return pop strobe |
| pc_i | input | 16 | Return address to save |
| ccr_i | input | 8 | Live condition register |
| bank_a_i | input | 1 | Live bank select A |
| bank_b_i | input | 1 | Live bank select B |
| gie_i | input | 1 | Live interrupt enable |
| vec_base_i | input | 8 | Trap vector base (upper byte) |
| vec_num_i | input | 6 | Trap vector number |
| ret_g_i | input | 2 | Interrupt-enable restore control |
| ret_rf_i | input | 1 | Restore flags and banks |
| ret_pc_o | output | 16 | Program counter from the slot being popped |
| ccr_o | output | 8 | Condition register to load |
| bank_a_o | output | 1 | Bank select A to load |
| bank_b_o | output | 1 | Bank select B to load |
| gie_o | output | 1 | Interrupt enable to load |
| vec_pc_o | output | 16 | Trap target address |

## Verification
All pop results are combinational in the cycle `pop_i` is high. The bench therefore raises the strobe just after a falling edge and samples one nanosecond later, before the rising edge moves the pointer. `vec_pc_o` is due in the same cycle as `trap_i` and is sampled the same way. Push effects appear only through a later pop, so every push is one clock edge ahead of the pop that checks it.

// File: rtl/ras_pkg.sv
package ras_pkg;
    localparam int PC_W = 16;

    typedef struct packed {
        logic            gie;
        logic            bank_a;
        logic            bank_b;
        logic [3:0]      flags;
        logic [PC_W-1:0] pc;
    } ras_entry_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
    import ras_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_d;
    logic [IDX_W-1:0] ptr_inc;

    always_comb begin
        ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        rd_idx  = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
        wr_idx  = ptr_q;
    end

    always_comb begin
        ptr_d = ptr_q;
        unique case (op)
            OP_IDLE: ptr_d = ptr_q;
            OP_PUSH: ptr_d = ptr_inc;
            OP_POP:  ptr_d = rd_idx;
            default: ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < IDX_W'(DEPTH)); // R3
    AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && ptr_q == LAST) |=> (ptr_q == '0)); // R3
    AST_POP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && ptr_q == '0) |=> (ptr_q == LAST)); // R4
endmodule

// File: rtl/ras_store.sv
module ras_store
    import ras_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  ras_entry_t       wr_entry,
    output ras_entry_t       rd_entry
);
    ras_entry_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (op == OP_PUSH && wr_idx == IDX_W'(i))
                slots[i] <= wr_entry;
        end
    end

    assign rd_entry = slots[rd_idx];

    AST_PUSH_THEN_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op) == OP_PUSH && op == OP_POP) |-> (rd_entry == $past(wr_entry))); // R2
endmodule

// File: rtl/ras_restore.sv
module ras_restore
    import ras_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pop,
    input  ras_entry_t saved,
    input  logic [7:0] ccr_i,
    input  logic       bank_a_i,
    input  logic       bank_b_i,
    input  logic       gie_i,
    input  logic [1:0] ret_g_i,
    input  logic       ret_rf_i,
    output logic [7:0] ccr_o,
    output logic       bank_a_o,
    output logic       bank_b_o,
    output logic       gie_o
);
    always_comb begin
        ccr_o    = ccr_i;
        bank_a_o = bank_a_i;
        bank_b_o = bank_b_i;
        gie_o    = gie_i;
        if (pop) begin
            if (ret_rf_i) begin
                ccr_o    = {ccr_i[7:4], saved.flags};
                bank_a_o = saved.bank_a;
                bank_b_o = saved.bank_b;
            end
            if (ret_g_i[1])      gie_o = ret_g_i[0];
            else if (ret_g_i[0]) gie_o = saved.gie;
        end
    end

    AST_CCR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_o[7:4] == ccr_i[7:4]); // R7
    AST_GIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop || ret_g_i == 2'b00) |-> (gie_o == gie_i)); // R10
    AST_NO_RF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop || !ret_rf_i) |-> (ccr_o == ccr_i && bank_a_o == bank_a_i)); // R6
endmodule

// File: rtl/ctx_return_stack.sv
module ctx_return_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic        trap_i,
    input  logic        pop_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  ccr_i,
    input  logic        bank_a_i,
    input  logic        bank_b_i,
    input  logic        gie_i,
    input  logic [7:0]  vec_base_i,
    input  logic [5:0]  vec_num_i,
    input  logic [1:0]  ret_g_i,
    input  logic        ret_rf_i,
    output logic [15:0] ret_pc_o,
    output logic [7:0]  ccr_o,
    output logic        bank_a_o,
    output logic        bank_b_o,
    output logic        gie_o,
    output logic [15:0] vec_pc_o
);
    localparam int IDX_W = $clog2(DEPTH);

    ras_op_e          op;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    ras_entry_t       wr_entry;
    ras_entry_t       rd_entry;

    always_comb begin
        unique case ({push_i | trap_i, pop_i})
            2'b10, 2'b11: op = OP_PUSH;
            2'b01:        op = OP_POP;
            default:      op = OP_IDLE;
        endcase
    end

    always_comb begin
        wr_entry.gie    = gie_i;
        wr_entry.bank_a = bank_a_i;
        wr_entry.bank_b = bank_b_i;
        wr_entry.flags  = ccr_i[3:0];
        wr_entry.pc     = pc_i;
    end

    ras_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(op), .wr_idx(wr_idx), .rd_idx(rd_idx)
    );

    ras_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .op(op), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .wr_entry(wr_entry), .rd_entry(rd_entry)
    );

    ras_restore u_restore (
        .clk(clk), .rst_n(rst_n), .pop(op == OP_POP), .saved(rd_entry),
        .ccr_i(ccr_i), .bank_a_i(bank_a_i), .bank_b_i(bank_b_i), .gie_i(gie_i),
        .ret_g_i(ret_g_i), .ret_rf_i(ret_rf_i),
        .ccr_o(ccr_o), .bank_a_o(bank_a_o), .bank_b_o(bank_b_o), .gie_o(gie_o)
    );

    assign ret_pc_o = rd_entry.pc;
    assign vec_pc_o = {vec_base_i, 2'b00, vec_num_i};

    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !((push_i || trap_i) && pop_i)); // R12
    AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |-> (vec_pc_o[15:8] == vec_base_i && vec_pc_o[5:0] == vec_num_i)); // R11
endmodule

// File: tb/ctx_return_stack_tb.sv
module ctx_return_stack_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_i, trap_i, pop_i;
    logic [15:0] pc_i;
    logic [7:0]  ccr_i;
    logic        bank_a_i, bank_b_i, gie_i;
    logic [7:0]  vec_base_i;
    logic [5:0]  vec_num_i;
    logic [1:0]  ret_g_i;
    logic        ret_rf_i;
    logic [15:0] ret_pc_o;
    logic [7:0]  ccr_o;
    logic        bank_a_o, bank_b_o, gie_o;
    logic [15:0] vec_pc_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ctx_return_stack u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .trap_i(trap_i), .pop_i(pop_i),
        .pc_i(pc_i), .ccr_i(ccr_i), .bank_a_i(bank_a_i), .bank_b_i(bank_b_i),
        .gie_i(gie_i), .vec_base_i(vec_base_i), .vec_num_i(vec_num_i),
        .ret_g_i(ret_g_i), .ret_rf_i(ret_rf_i), .ret_pc_o(ret_pc_o),
        .ccr_o(ccr_o), .bank_a_o(bank_a_o), .bank_b_o(bank_b_o), .gie_o(gie_o),
        .vec_pc_o(vec_pc_o)
    );

    // row: g(2) rf sgie sflags(4) sba sbb ccr_in(8) igie iba ibb | egie eccr(8) eba ebb
    localparam logic [31:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b1, 4'b1010, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b1, 8'h30, 1'b0, 1'b1, 1'b0, 1'b1, 8'h30, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 4'b0110, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF6, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5F, 1'b0, 1'b0},
        {2'b11, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0C, 1'b0, 1'b0},
        {2'b00, 1'b1, 1'b0, 4'b1000, 1'b0, 1'b1, 8'h97, 1'b1, 1'b1, 1'b0, 1'b1, 8'h98, 1'b0, 1'b1},
        {2'b11, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b1, 4'b0101, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        push_i = 0; trap_i = 0; pop_i = 0;
        ret_g_i = 2'b00; ret_rf_i = 0;
    endtask

    task automatic do_push(input logic [15:0] pc, input logic [3:0] fl,
                           input logic ba, input logic bb, input logic gie);
        @(negedge clk);
        idle();
        push_i = 1; pc_i = pc; ccr_i = {4'h0, fl};
        bank_a_i = ba; bank_b_i = bb; gie_i = gie;
        @(posedge clk);
    endtask

    task automatic do_pop(input string req, input logic [15:0] exp_pc);
        @(negedge clk);
        idle();
        pop_i = 1;
        #1 check(req, {16'h0, ret_pc_o}, {16'h0, exp_pc});
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        pc_i = 0; ccr_i = 0; bank_a_i = 0; bank_b_i = 0; gie_i = 0;
        vec_base_i = 0; vec_num_i = 0;
        rst_n = 0;
        do_reset();

        // R1: first push after reset lands where the first pop reads
        do_push(16'hBEEF, 4'h0, 0, 0, 0);
        do_pop("R1", 16'hBEEF);

        // R5..R10 table walk: push saved context, pop with live inputs
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            logic [15:0] pcv;
            v = VEC[i];
            pcv = 16'h1000 + 16'(i) * 16'h0111;
            do_push(pcv, v[27:24], v[23], v[22], v[28]);
            @(negedge clk);
            idle();
            pop_i = 1; ret_g_i = v[31:30]; ret_rf_i = v[29];
            ccr_i = v[21:14]; gie_i = v[13]; bank_a_i = v[12]; bank_b_i = v[11];
            #1;
            check("R5 pc", {16'h0, ret_pc_o}, {16'h0, pcv});
            check("R7/R6 ccr", {24'h0, ccr_o}, {24'h0, v[9:2]});
            check("R7/R6 banks", {30'h0, bank_a_o, bank_b_o}, {30'h0, v[1], v[0]});
            check("R8/R9/R10 gie", {31'h0, gie_o}, {31'h0, v[10]});
            @(posedge clk);
        end

        // R6 / R10: no pop in progress, outputs follow inputs even with rf/g set
        @(negedge clk);
        idle();
        ret_rf_i = 1; ret_g_i = 2'b11; ccr_i = 8'h6B; gie_i = 0; bank_a_i = 1; bank_b_i = 0;
        #1;
        check("R6 idle ccr", {24'h0, ccr_o}, 32'h6B);
        check("R6 idle banks", {30'h0, bank_a_o, bank_b_o}, 32'h2);
        check("R10 idle gie", {31'h0, gie_o}, 32'h0);

        // R2: LIFO
        do_reset();
        do_push(16'h0A01, 4'h1, 0, 0, 0);
        do_push(16'h0A02, 4'h2, 0, 0, 0);
        do_push(16'h0A03, 4'h3, 0, 0, 0);
        do_pop("R2", 16'h0A03);
        do_pop("R2", 16'h0A02);
        do_pop("R2", 16'h0A01);

        // R4: twelve pushes bring the pointer back to 0; pop reads slot 11
        do_reset();
        for (int i = 0; i < 12; i++) do_push(16'h2000 + 16'(i), 4'h0, 0, 0, 0);
        do_pop("R4", 16'h200B);
        do_pop("R4", 16'h200A);

        // R3: thirteen pushes overwrite the oldest
        do_reset();
        for (int i = 0; i < 13; i++) do_push(16'h3000 + 16'(i), 4'h0, 0, 0, 0);
        for (int i = 12; i >= 1; i--) do_pop("R3", 16'h3000 + 16'(i));
        do_pop("R3 wrap", 16'h300C);

        // R11: trap pushes and forms the vector address
        do_reset();
        @(negedge clk);
        idle();
        trap_i = 1; pc_i = 16'h4321; ccr_i = 8'h05; gie_i = 1; bank_a_i = 0; bank_b_i = 1;
        vec_base_i = 8'h3A; vec_num_i = 6'h15;
        #1 check("R11 vector", {16'h0, vec_pc_o}, 32'h3A15);
        @(posedge clk);
        @(negedge clk);
        idle();
        pop_i = 1; ret_g_i = 2'b01; ret_rf_i = 1; ccr_i = 8'hC0; gie_i = 0;
        #1;
        check("R11 pc", {16'h0, ret_pc_o}, 32'h4321);
        check("R11 ctx", {23'h0, gie_o, ccr_o}, {23'h0, 1'b1, 8'hC5});
        @(posedge clk);

        // R12: strobes in adjacent cycles each take effect
        do_reset();
        do_push(16'h5001, 4'h0, 0, 0, 0);
        do_pop("R12", 16'h5001);
        do_push(16'h5002, 4'h0, 0, 0, 0);
        do_push(16'h5003, 4'h0, 0, 0, 0);
        do_pop("R12", 16'h5003);
        do_push(16'h5004, 4'h0, 0, 0, 0);
        do_pop("R12", 16'h5004);
        do_pop("R12", 16'h5002);

        @(negedge clk);
        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule